// File: doc/BRIEF.md
# Pulse-Pause Interval Frame Decoder

This block recovers reader-to-tag frames from a pulse-pause coded envelope. The demodulated envelope level enters through a two-flop synchronizer, and each rising edge of the synchronized level marks a symbol boundary. A timer counts tick-enable cycles between consecutive rising edges. When an edge arrives, the elapsed interval is compared against two tolerance windows, one for a logic 1 and one for a logic 0.

Decoded bits are gathered least significant bit first into a frame buffer. A frame opens with its first decoded bit. It closes when a rising edge falls outside both windows or when no edge arrives within the longest legal interval. A closed frame with enough bits is published with a single-cycle strobe. A frame that is too short is dropped silently. The consumer reads the data word and the bit count on the strobe cycle, or at any time until the next strobe.

Top module: `pp_frame_decoder`

## Requirements
- R1: `env_level` passes through two synchronizer flops and then through an edge register. A rising edge at the pin is acted on at the third clock edge after it is first sampled.
- R2: The interval counter counts tick-enabled clock edges since the last rising edge. The edge that restarts it counts its own tick. The counter stops advancing once it exceeds 2400 ticks (20 times the 1-bit target), so after a long idle no edge can decode as a bit.
- R3: A rising edge whose interval lies strictly between 100 and 140 ticks (101 to 139 inclusive) appends a 1 bit.
- R4: A rising edge whose interval lies strictly between 40 and 80 ticks (41 to 79 inclusive) appends a 0 bit.
- R5: Bits are stored least significant bit first: the n-th decoded bit goes to `frame_data[n-1]`. The bit count saturates at 32, and bits beyond the 32nd are dropped.
- R6: A rising edge outside both windows closes the open frame. While no frame is open, such an edge adds nothing and raises no strobe. The edge also restarts the interval counter.
- R7: While a frame is open, the frame closes when the interval counter reaches 140 ticks without a new rising edge.
- R8: A frame that closes with 4 bits or fewer is discarded. It raises no `frame_valid`, and `frame_data` and `frame_bits` keep their previous values.
- R9: A frame of 5 or more bits raises `frame_valid` for exactly one cycle, one clock after the closing event, with its data and count. These outputs stay stable until the next strobe, and the next frame starts empty.
- R10: After synchronous reset, `frame_valid`, `frame_data` and `frame_bits` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| env_level | input | 1 | Demodulated envelope level, asynchronous to clk |
| tick_en | input | 1 | Timing tick enable, one pulse per tick |
| frame_valid | output | 1 | One-cycle strobe for an accepted frame |
| frame_data | output | 32 | Frame bits, first received in bit 0 |
| frame_bits | output | 6 | Number of bits in the frame, 0 to 32 |

## Verification
The assertions assume that `env_level` returns low between pulses, so that every bit owns exactly one rising edge. They also assume that `tick_en` is a plain enable whose rate is irrelevant to the decoding rules, since the windows are defined in ticks. The stimulus always drives a 30-tick low pause ahead of each rising edge and holds the level between edges. It changes inputs only on the falling clock edge and counts intervals in enabled ticks. Boundary intervals are exercised with a tick on every cycle, where the interval the bench sends equals the interval the counter sees.

// File: rtl/pp_dec_pkg.sv
package pp_dec_pkg;

    // Default timing constants, in ticks
    localparam int ONE_TARGET_D  = 120;
    localparam int ZERO_TARGET_D = 60;
    localparam int TOLERANCE_D   = 20;
    localparam int IDLE_MULT_D   = 20;
    localparam int MIN_BITS_D    = 5;
    localparam int DATA_W_D      = 32;
    localparam int SYNC_STAGES_D = 2;

    typedef enum logic [1:0] {
        SYM_NONE = 2'd0,
        SYM_ZERO = 2'd1,
        SYM_ONE  = 2'd2,
        SYM_BAD  = 2'd3
    } sym_e;

    typedef struct packed {
        sym_e kind;
        logic expired;
    } ival_evt_t;

    // Strict window test: target-tol < value < target+tol
    function automatic logic in_window(input int value, input int target, input int tol);
        return (value > (target - tol)) && (value < (target + tol));
    endfunction

endpackage

// File: rtl/pp_edge_sync.sv
module pp_edge_sync #(
    parameter int SYNC_STAGES = pp_dec_pkg::SYNC_STAGES_D
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
        end else begin
            shreg <= {shreg[SH_W-2:0], din};
        end
    end

    // Synchronized level is the last sync stage; the extra stage holds the previous level
    assign rise = shreg[SH_W-2] & ~shreg[SH_W-1];

endmodule

// File: rtl/pp_interval_timer.sv
module pp_interval_timer
    import pp_dec_pkg::*;
#(
    parameter int ONE_TARGET  = ONE_TARGET_D,
    parameter int ZERO_TARGET = ZERO_TARGET_D,
    parameter int TOLERANCE   = TOLERANCE_D,
    parameter int IDLE_MULT   = IDLE_MULT_D,
    parameter int CNT_W       = $clog2(IDLE_MULT_D * ONE_TARGET_D + 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise,
    input  logic             tick_en,
    output logic [CNT_W-1:0] ival_cnt,
    output ival_evt_t        evt
);
    localparam int STOP_LIM = IDLE_MULT * ONE_TARGET;
    localparam int EXPIRE   = ONE_TARGET + TOLERANCE;
    localparam logic [CNT_W-1:0] STOP_C   = CNT_W'(STOP_LIM);
    localparam logic [CNT_W-1:0] EXPIRE_C = CNT_W'(EXPIRE);

    logic hit_one;
    logic hit_zero;

    always_comb begin
        hit_one  = in_window(int'(ival_cnt), ONE_TARGET, TOLERANCE);
        hit_zero = in_window(int'(ival_cnt), ZERO_TARGET, TOLERANCE);
        evt.kind = SYM_NONE;
        if (rise) begin
            if (hit_one) begin
                evt.kind = SYM_ONE;
            end else if (hit_zero) begin
                evt.kind = SYM_ZERO;
            end else begin
                evt.kind = SYM_BAD;
            end
        end
        evt.expired = (ival_cnt >= EXPIRE_C);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ival_cnt <= '0;
        end else if (rise) begin
            ival_cnt <= CNT_W'(tick_en);
        end else if (tick_en && (ival_cnt <= STOP_C)) begin
            ival_cnt <= ival_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pp_frame_collect.sv
module pp_frame_collect
    import pp_dec_pkg::*;
#(
    parameter int DATA_W   = DATA_W_D,
    parameter int MIN_BITS = MIN_BITS_D
) (
    input  logic                       clk,
    input  logic                       rst,
    input  ival_evt_t                  evt,
    output logic                       frame_active,
    output logic [$clog2(DATA_W+1)-1:0] buf_count,
    output logic                       frame_valid,
    output logic [DATA_W-1:0]          frame_data,
    output logic [$clog2(DATA_W+1)-1:0] frame_bits
);
    localparam int CW    = $clog2(DATA_W + 1);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [CW-1:0] FULL_C = CW'(DATA_W);
    localparam logic [CW-1:0] MIN_C  = CW'(MIN_BITS);

    logic [DATA_W-1:0] buf_data;
    logic              got_bit;
    logic              bit_val;
    logic              close_frame;

    always_comb begin
        got_bit     = (evt.kind == SYM_ONE) || (evt.kind == SYM_ZERO);
        bit_val     = (evt.kind == SYM_ONE);
        close_frame = frame_active && ((evt.kind == SYM_BAD) || evt.expired);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_data     <= '0;
            buf_count    <= '0;
            frame_active <= 1'b0;
            frame_valid  <= 1'b0;
            frame_data   <= '0;
            frame_bits   <= '0;
        end else begin
            frame_valid <= 1'b0;
            if (got_bit) begin
                frame_active <= 1'b1;
                if (buf_count < FULL_C) begin
                    buf_data[buf_count[IDX_W-1:0]] <= bit_val;
                    buf_count <= buf_count + 1'b1;
                end
            end else if (close_frame) begin
                frame_active <= 1'b0;
                buf_data     <= '0;
                buf_count    <= '0;
                if (buf_count >= MIN_C) begin
                    frame_valid <= 1'b1;
                    frame_data  <= buf_data;
                    frame_bits  <= buf_count;
                end
            end
        end
    end

endmodule

// File: rtl/pp_frame_decoder.sv
module pp_frame_decoder
    import pp_dec_pkg::*;
#(
    parameter int ONE_TARGET  = ONE_TARGET_D,
    parameter int ZERO_TARGET = ZERO_TARGET_D,
    parameter int TOLERANCE   = TOLERANCE_D,
    parameter int IDLE_MULT   = IDLE_MULT_D,
    parameter int MIN_BITS    = MIN_BITS_D,
    parameter int DATA_W      = DATA_W_D,
    parameter int SYNC_STAGES = SYNC_STAGES_D
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        env_level,
    input  logic                        tick_en,
    output logic                        frame_valid,
    output logic [DATA_W-1:0]           frame_data,
    output logic [$clog2(DATA_W+1)-1:0] frame_bits
);
    localparam int TCNT_W = $clog2(IDLE_MULT * ONE_TARGET + 2);
    localparam int BCNT_W = $clog2(DATA_W + 1);

    logic              edge_rise;
    logic [TCNT_W-1:0] ival_cnt;
    ival_evt_t         ival_evt;
    logic              frame_active;
    logic [BCNT_W-1:0] buf_count;

    pp_edge_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (env_level),
        .rise (edge_rise)
    );

    pp_interval_timer #(
        .ONE_TARGET  (ONE_TARGET),
        .ZERO_TARGET (ZERO_TARGET),
        .TOLERANCE   (TOLERANCE),
        .IDLE_MULT   (IDLE_MULT),
        .CNT_W       (TCNT_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .rise     (edge_rise),
        .tick_en  (tick_en),
        .ival_cnt (ival_cnt),
        .evt      (ival_evt)
    );

    pp_frame_collect #(
        .DATA_W   (DATA_W),
        .MIN_BITS (MIN_BITS)
    ) u_collect (
        .clk          (clk),
        .rst          (rst),
        .evt          (ival_evt),
        .frame_active (frame_active),
        .buf_count    (buf_count),
        .frame_valid  (frame_valid),
        .frame_data   (frame_data),
        .frame_bits   (frame_bits)
    );

endmodule

// File: rtl/pp_frame_decoder_chk.sv
module pp_frame_decoder_chk #(
    parameter int DATA_W     = 32,
    parameter int MIN_BITS   = 5,
    parameter int ONE_TARGET = 120,
    parameter int TOLERANCE  = 20,
    parameter int IDLE_MULT  = 20,
    parameter int TCNT_W     = 12
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        frame_valid,
    input logic [DATA_W-1:0]           frame_data,
    input logic [$clog2(DATA_W+1)-1:0] frame_bits,
    input logic                        frame_active,
    input logic [$clog2(DATA_W+1)-1:0] buf_count,
    input logic [TCNT_W-1:0]           ival_cnt
);
    localparam int BW = $clog2(DATA_W + 1);
    localparam logic [TCNT_W-1:0] CAP_C = TCNT_W'(IDLE_MULT * ONE_TARGET + 1);
    localparam logic [TCNT_W-1:0] EXP_C = TCNT_W'(ONE_TARGET + TOLERANCE);
    localparam logic [BW-1:0]     MIN_C = BW'(MIN_BITS);
    localparam logic [BW-1:0]     MAX_C = BW'(DATA_W);

    p_cnt_cap_r2: assert property (@(posedge clk) disable iff (rst)
        ival_cnt <= CAP_C);

    p_bits_cap_r5: assert property (@(posedge clk) disable iff (rst)
        (frame_bits <= MAX_C) && (buf_count <= MAX_C));

    p_idle_empty_r6: assert property (@(posedge clk) disable iff (rst)
        !frame_active |-> (buf_count == '0));

    p_timeout_r7: assert property (@(posedge clk) disable iff (rst)
        (frame_active && (ival_cnt >= EXP_C)) |=> !frame_active);

    p_min_len_r8: assert property (@(posedge clk) disable iff (rst)
        frame_valid |-> (frame_bits >= MIN_C));

    p_one_cycle_r9: assert property (@(posedge clk) disable iff (rst)
        frame_valid |=> !frame_valid);

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !frame_valid |-> ($stable(frame_data) && $stable(frame_bits)));

endmodule

bind pp_frame_decoder pp_frame_decoder_chk #(
    .DATA_W     (DATA_W),
    .MIN_BITS   (MIN_BITS),
    .ONE_TARGET (ONE_TARGET),
    .TOLERANCE  (TOLERANCE),
    .IDLE_MULT  (IDLE_MULT),
    .TCNT_W     (TCNT_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .frame_valid  (frame_valid),
    .frame_data   (frame_data),
    .frame_bits   (frame_bits),
    .frame_active (frame_active),
    .buf_count    (buf_count),
    .ival_cnt     (ival_cnt)
);

// File: tb/pp_frame_decoder_test.sv
module pp_frame_decoder_test;

    localparam int ONE_T   = 120;
    localparam int ZERO_T  = 60;
    localparam int TOL     = 20;
    localparam int CAP_LIM = 2400;
    localparam int MINB    = 5;
    localparam int MAXB    = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        env_level = 1'b1;
    logic        tick_en = 1'b0;
    logic        frame_valid;
    logic [31:0] frame_data;
    logic [5:0]  frame_bits;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int tick_div = 1;
    int div_ctr = 0;

    always #2 clk = ~clk;

    pp_frame_decoder uut (
        .clk         (clk),
        .rst         (rst),
        .env_level   (env_level),
        .tick_en     (tick_en),
        .frame_valid (frame_valid),
        .frame_data  (frame_data),
        .frame_bits  (frame_bits)
    );

    // ---------------- tick generator ----------------
    always @(negedge clk) begin
        if (div_ctr >= tick_div - 1) begin
            tick_en = 1'b1;
            div_ctr = 0;
        end else begin
            tick_en = 1'b0;
            div_ctr = div_ctr + 1;
        end
    end

    // ---------------- behavioural reference model ----------------
    bit        m_sync[$];
    bit        m_prev;
    int        m_cnt;
    bit        m_open;
    bit        m_bits[$];
    bit        m_valid;
    bit [31:0] m_data;
    int        m_nbits;

    task automatic m_close();
        m_open = 1'b0;
        if (m_bits.size() >= MINB) begin
            m_valid = 1'b1;
            m_data  = '0;
            foreach (m_bits[i]) m_data[i] = m_bits[i];
            m_nbits = m_bits.size();
        end
        m_bits.delete();
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_sync = '{1'b0, 1'b0};
            m_prev = 1'b0;
            m_cnt = 0;
            m_open = 1'b0;
            m_bits.delete();
            m_valid = 1'b0;
            m_data = '0;
            m_nbits = 0;
        end else begin
            bit lvl;
            bit edge_seen;
            int elapsed;
            lvl = m_sync[1];
            edge_seen = lvl && !m_prev;
            elapsed = m_cnt;
            m_valid = 1'b0;
            if (edge_seen && elapsed > ONE_T - TOL && elapsed < ONE_T + TOL) begin
                m_open = 1'b1;
                if (m_bits.size() < MAXB) m_bits.push_back(1'b1);
            end else if (edge_seen && elapsed > ZERO_T - TOL && elapsed < ZERO_T + TOL) begin
                m_open = 1'b1;
                if (m_bits.size() < MAXB) m_bits.push_back(1'b0);
            end else if (m_open && (edge_seen || elapsed >= ONE_T + TOL)) begin
                m_close();
            end
            if (edge_seen) m_cnt = tick_en ? 1 : 0;
            else if (tick_en && m_cnt <= CAP_LIM) m_cnt = m_cnt + 1;
            m_prev = lvl;
            m_sync[1] = m_sync[0];
            m_sync[0] = env_level;
        end
    end

    // ---------------- per-cycle comparison and capture ----------------
    int        nvalid = 0;
    bit [31:0] cap_data = '0;
    int        cap_bits = 0;

    always @(negedge clk) begin
        cycles = cycles + 1;
        if (!rst) begin
            checks = checks + 1;
            if (frame_valid !== m_valid || frame_data !== m_data || frame_bits !== 6'(m_nbits)) begin
                errors = errors + 1;
                $display("FAIL R9 model compare at cycle %0d: valid=%b data=%h bits=%0d expected valid=%b data=%h bits=%0d",
                         cycles, frame_valid, frame_data, frame_bits, m_valid, m_data, m_nbits);
            end
            if (frame_valid === 1'b1) begin
                nvalid = nvalid + 1;
                cap_data = frame_data;
                cap_bits = int'(frame_bits);
            end
        end
        if (cycles > 190000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired: cycles=%0d expected below 190000", cycles);
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic check(input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        for (int k = 0; k < n; ) begin
            @(posedge clk);
            if (tick_en) k = k + 1;
        end
        @(negedge clk);
    endtask

    // Pause then rising edge; level idles high
    task automatic ref_edge();
        env_level = 1'b0;
        wait_ticks(30);
        env_level = 1'b1;
    endtask

    // Next rising edge comes 'ival' ticks after the previous one
    task automatic bit_gap(input int ival);
        wait_ticks(ival - 30);
        env_level = 1'b0;
        wait_ticks(30);
        env_level = 1'b1;
    endtask

    task automatic send_bits(input bit [63:0] v, input int n);
        for (int i = 0; i < n; i++) bit_gap(v[i] ? ONE_T : ZERO_T);
    endtask

    function automatic bit [31:0] pack(input bit [63:0] v, input int n);
        bit [31:0] r = '0;
        for (int i = 0; i < n && i < 32; i++) r[i] = v[i];
        return r;
    endfunction

    // ---------------- test sequence ----------------
    initial begin
        int nv0;
        repeat (4) @(negedge clk);
        // R10: reset values
        check("R10 frame_valid in reset", frame_valid, 0);
        check("R10 frame_data in reset", frame_data, 0);
        check("R10 frame_bits in reset", frame_bits, 0);
        rst = 1'b0;

        // R2: long idle saturates the counter; first edge afterwards decodes nothing
        wait_ticks(2600);
        nv0 = nvalid;
        ref_edge();
        wait_ticks(300);
        check("R2 edge after idle gives no frame", nvalid, nv0);

        // R3 R4 R7: 8-bit frame closed by timeout
        ref_edge();
        send_bits(64'hB2, 8);
        wait_ticks(200);
        check("R7 timeout closes frame", nvalid, nv0 + 1);
        check("R3 R4 data LSB first", cap_data, pack(64'hB2, 8));
        check("R9 bit count", cap_bits, 8);

        // R8: 4-bit frame discarded, outputs unchanged
        nv0 = nvalid;
        ref_edge();
        send_bits(64'h5, 4);
        wait_ticks(200);
        check("R8 short frame no strobe", nvalid, nv0);
        check("R8 data held", frame_data, pack(64'hB2, 8));
        check("R8 bits held", frame_bits, 8);

        // R8 boundary: 5 bits accepted
        ref_edge();
        send_bits(64'h16, 5);
        wait_ticks(200);
        check("R8 five bits accepted", nvalid, nv0 + 1);
        check("R8 five-bit data", cap_data, pack(64'h16, 5));
        check("R8 five-bit count", cap_bits, 5);

        // R6: out-of-window edge closes frame; that edge starts the next frame
        nv0 = nvalid;
        ref_edge();
        send_bits(64'h2D, 6);
        bit_gap(90);
        wait_ticks(10);
        check("R6 bad edge closes frame", nvalid, nv0 + 1);
        check("R6 first frame data", cap_data, pack(64'h2D, 6));
        send_bits(64'h1B, 5);
        wait_ticks(200);
        check("R6 following frame accepted", nvalid, nv0 + 2);
        check("R6 following frame data", cap_data, pack(64'h1B, 5));

        // R6: bad edges while idle are ignored
        nv0 = nvalid;
        ref_edge();
        bit_gap(90);
        bit_gap(30 + 5);
        bit_gap(200);
        wait_ticks(200);
        check("R6 idle bad edges ignored", nvalid, nv0);
        check("R6 idle data held", frame_data, pack(64'h1B, 5));

        // R3 R4 window edges: 101,139 -> 1 ; 41,79 -> 0 ; then 100 closes
        nv0 = nvalid;
        ref_edge();
        bit_gap(101); bit_gap(139); bit_gap(41); bit_gap(79); bit_gap(120); bit_gap(60);
        bit_gap(100);
        wait_ticks(10);
        check("R3 R4 inner window limits", cap_data, 32'b010011);
        check("R3 window count", cap_bits, 6);
        // 40 and 80 are outside
        ref_edge();
        send_bits(64'h1F, 5);
        bit_gap(80);
        wait_ticks(10);
        check("R4 interval 80 closes frame", cap_data, pack(64'h1F, 5));
        send_bits(64'h0A, 5);
        bit_gap(40);
        wait_ticks(10);
        check("R4 interval 40 closes frame", cap_data, pack(64'h0A, 5));
        check("R4 frames counted", nvalid, nv0 + 3);

        // R5: 40 bits, saturate at 32
        ref_edge();
        send_bits(64'h00C3_A5F0_9E61_7B2D, 40);
        wait_ticks(200);
        check("R5 saturated count", cap_bits, 32);
        check("R5 first 32 bits kept", cap_data, 32'h9E61_7B2D);

        // R1 R2: gated ticks, one tick every 3 clocks
        tick_div = 3;
        nv0 = nvalid;
        wait_ticks(10);
        ref_edge();
        send_bits(64'h35, 7);
        wait_ticks(200);
        check("R1 R2 gated ticks frame", nvalid, nv0 + 1);
        check("R2 gated data", cap_data, pack(64'h35, 7));
        check("R2 gated count", cap_bits, 7);
        tick_div = 1;
        wait_ticks(20);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule